// File: doc/BRIEF.md
# Go/No-Go Memory Test Suite Sequencer

This block runs a fixed, built-in memory test suite. A start pulse is accepted only when the pattern code on its select input is 111111. The block then drives a downstream pattern engine through five sub-tests, one after another. For each sub-test it presents a pattern code and a data seed, pulses a one-cycle launch strobe, and waits for the engine to report completion together with a fail flag.

Fail flags are merged across all the steps. When the suite ends, the block raises a one-cycle done strobe and presents a single go result. Go is high only if no step failed.

The suite has a fixed order. Four checkerboard passes come first: write, read, write, read, all using the caller's seed. A read-write-read march in y-fast order comes last, with the constant nibble 0x6 as its seed. This constant is either zero-extended or repeated across the data width, as a parameter selects. An optional stop-on-fail input ends the suite right after the first failing step.

Top module: `gonogo_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `go` and `sub_start` are all 0.
- R2: A `start` pulse in idle launches the suite only when `sel_code` equals 111111. Any other code leaves `busy` at 0 and produces no `sub_start`.
- R3: The steps run in this fixed order, each with its own code on `sub_code`. Steps 1 and 3 use 000010 (checkerboard write). Steps 2 and 4 use 000011 (checkerboard read). Steps 1 to 4 carry `user_seed` on `sub_seed`. Step 5 uses 001001 (read-write-read march, y-fast).
- R4: During step 5, `sub_seed` is the nibble 0110. With `SEED_REPL`=0 it is zero-extended, and with `SEED_REPL`=1 it is repeated from bit 0 upward (bit i = bit i mod 4 of 0110).
- R5: Each step issues exactly one single-cycle `sub_start`. The first arrives in the cycle after the accepted `start`, and each later one arrives in the cycle after the previous step's `sub_done`. No `sub_start` appears while a step is pending.
- R6: A `sub_fail` high together with `sub_done` marks the suite as failed. With `stop_on_fail` at 0, all five steps still run.
- R7: With `stop_on_fail` at 1, the suite ends after the first step that reports a fail. No further `sub_start` is issued.
- R8: `done` is high for exactly one cycle, in the cycle after the final step's `sub_done`. `go` then shows the inverse of the merged fail and holds until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored. The running suite keeps its step order and its step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the selected pattern |
| sel_code | input | 6 | Pattern code; 111111 selects this suite |
| user_seed | input | DW | Caller data seed for the checkerboard steps |
| stop_on_fail | input | 1 | End the suite after the first failing step |
| sub_code | output | 6 | Pattern code for the current step |
| sub_seed | output | DW | Data seed for the current step |
| sub_start | output | 1 | One-cycle launch of the current step |
| sub_done | input | 1 | Current step has finished |
| sub_fail | input | 1 | Step result, valid with sub_done |
| busy | output | 1 | Suite in progress |
| done | output | 1 | One-cycle end-of-suite strobe |
| go | output | 1 | Overall pass result |

## Verification
The bench builds the block with `DW`=12 and `SEED_REPL`=1. The 12-bit width is not a power of two but is a multiple of the 4-bit seed, so the step-5 seed is expected to be 0x666. A replication fault shows up in the upper nibbles, where zero-extension would leave zeros. A narrow width also lets each vector use a distinct user seed, so a step that wrongly takes the fixed seed, or the reverse, is caught. Fail masks place the first failure at several different steps, with and without stop-on-fail, which makes early termination visible at each step position.

// File: rtl/gonogo_seq.sv
module gonogo_seq #(
  parameter int          DW         = 32,
  parameter bit          SEED_REPL  = 1'b0,
  parameter logic [5:0]  SUITE_CODE = 6'b111111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    sel_code,
  input  logic [DW-1:0] user_seed,
  input  logic          stop_on_fail,
  output logic [5:0]    sub_code,
  output logic [DW-1:0] sub_seed,
  output logic          sub_start,
  input  logic          sub_done,
  input  logic          sub_fail,
  output logic          busy,
  output logic          done,
  output logic          go
);
  localparam int         NSTEPS   = 5;
  localparam int         SW       = $clog2(NSTEPS);
  localparam logic [3:0] FIX_NIB  = 4'h6;
  localparam logic [5:0] CODE_CBW = 6'b000010;
  localparam logic [5:0] CODE_CBR = 6'b000011;
  localparam logic [5:0] CODE_RWR = 6'b001001;

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} st_t;

  st_t           st;
  logic [SW-1:0] step;
  logic          fail_q, done_q, go_q;
  logic [DW-1:0] fix_seed;
  logic          fail_n, last_step;

  for (genvar i = 0; i < DW; i++) begin : g_seed
    if (SEED_REPL) begin : g_rep
      assign fix_seed[i] = FIX_NIB[i % 4];
    end else if (i < 4) begin : g_low
      assign fix_seed[i] = FIX_NIB[i];
    end else begin : g_zero
      assign fix_seed[i] = 1'b0;
    end
  end

  always_comb begin
    case (step)
      SW'(0), SW'(2): sub_code = CODE_CBW;
      SW'(1), SW'(3): sub_code = CODE_CBR;
      default:        sub_code = CODE_RWR;
    endcase
  end

  assign sub_seed  = (step == SW'(NSTEPS-1)) ? fix_seed : user_seed;
  assign sub_start = (st == S_LAUNCH);
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign go        = go_q;
  assign fail_n    = fail_q | sub_fail;
  assign last_step = (step == SW'(NSTEPS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start && sel_code == SUITE_CODE) begin
          st     <= S_LAUNCH;
          step   <= '0;
          fail_q <= 1'b0;
          go_q   <= 1'b0;
        end
        S_LAUNCH: st <= S_WAIT;
        S_WAIT: if (sub_done) begin
          fail_q <= fail_n;
          if (last_step || (stop_on_fail && fail_n)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            go_q   <= ~fail_n;
          end else begin
            st   <= S_LAUNCH;
            step <= step + SW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module gonogo_seq_chk #(
  parameter int DW        = 32,
  parameter bit SEED_REPL = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    sub_code,
  input logic [DW-1:0] sub_seed,
  input logic          sub_start,
  input logic          sub_done,
  input logic          busy,
  input logic          done
);
  function automatic logic [DW-1:0] fixed_seed();
    logic [DW-1:0] v;
    for (int i = 0; i < DW; i++)
      v[i] = SEED_REPL ? ((4'h6 >> (i % 4)) & 4'h1) != 0 : (i < 4 ? ((4'h6 >> i) & 4'h1) != 0 : 1'b0);
    return v;
  endfunction

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sub_start |=> !sub_start); // R5
  AST_START_IN_RUN:    assert property (@(posedge clk) disable iff (!rst_n) sub_start |-> busy); // R2
  AST_DONE_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AFTER_SUB:  assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(sub_done)); // R8
  AST_DONE_ENDS_RUN:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
  AST_MARCH_SEED:      assert property (@(posedge clk) disable iff (!rst_n) (sub_start && sub_code == 6'b001001) |-> sub_seed == fixed_seed()); // R4
endmodule

bind gonogo_seq gonogo_seq_chk #(.DW(DW), .SEED_REPL(SEED_REPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_code(sub_code), .sub_seed(sub_seed),
  .sub_start(sub_start), .sub_done(sub_done), .busy(busy), .done(done)
);

// File: tb/sim_gonogo_seq.sv
module sim_gonogo_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam logic [DW-1:0] MARCH_SEED = 12'h666;
  localparam int NV = 8;
  // {fail_mask[4:0], stop, exp_go, exp_steps[2:0], poke_start}
  localparam logic [10:0] VEC [NV] = '{
    {5'b00000, 1'b0, 1'b1, 3'd5, 1'b0},
    {5'b00001, 1'b0, 1'b0, 3'd5, 1'b1},
    {5'b10000, 1'b0, 1'b0, 3'd5, 1'b0},
    {5'b00100, 1'b1, 1'b0, 3'd3, 1'b0},
    {5'b00001, 1'b1, 1'b0, 3'd1, 1'b1},
    {5'b00000, 1'b1, 1'b1, 3'd5, 1'b0},
    {5'b10000, 1'b1, 1'b0, 3'd5, 1'b0},
    {5'b01010, 1'b0, 1'b0, 3'd5, 1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0, stop_on_fail = 0, sub_done = 0, sub_fail = 0;
  logic [5:0] sel_code = '0;
  logic [DW-1:0] user_seed = '0;
  logic [5:0] sub_code;
  logic [DW-1:0] sub_seed;
  logic sub_start, busy, done, go;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gonogo_seq #(.DW(DW), .SEED_REPL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_code(sel_code), .user_seed(user_seed),
    .stop_on_fail(stop_on_fail), .sub_code(sub_code), .sub_seed(sub_seed), .sub_start(sub_start),
    .sub_done(sub_done), .sub_fail(sub_fail), .busy(busy), .done(done), .go(go)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_code(input int n);
    if (n == 4) return 6'b001001;
    return (n % 2) ? 6'b000011 : 6'b000010;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [4:0] mask, input bit stp, input bit exp_go,
                     input int exp_n, input bit poke, input logic [DW-1:0] seed);
    int n = 0;
    int w = 0;
    bit fin = 0;
    user_seed = seed; stop_on_fail = stp; sel_code = 6'b111111;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(busy == 1'b1, "R2", busy, 1);
    check(sub_start == 1'b1, "R5", sub_start, 1);
    while (!fin && w < 200) begin
      if (sub_start) begin
        check(sub_code == exp_code(n), "R3", sub_code, exp_code(n));
        check(sub_seed == (n == 4 ? MARCH_SEED : seed), n == 4 ? "R4" : "R3",
              sub_seed, n == 4 ? MARCH_SEED : seed);
        @(negedge clk);
        check(sub_start == 1'b0, "R5", sub_start, 0);
        if (poke && n == 0) begin
          start = 1;
          @(negedge clk) start = 0;
          check(sub_start == 1'b0 && busy == 1'b1, "R9", sub_start, 0);
        end
        @(negedge clk);
        check(sub_start == 1'b0, "R5", sub_start, 0);
        sub_done = 1; sub_fail = mask[n]; n++;
        @(negedge clk);
        sub_done = 0; sub_fail = 0;
        if (done) fin = 1;
      end else begin
        @(negedge clk); w++;
      end
    end
    check(fin, "R8", fin, 1);
    check(n == exp_n, stp ? "R7" : "R6", n, exp_n);
    check(go == exp_go, "R6", go, exp_go);
    @(negedge clk);
    check(done == 1'b0, "R8", done, 0);
    check(busy == 1'b0 && sub_start == 1'b0, "R7", busy, 0);
    repeat (3) @(negedge clk);
    check(go == exp_go, "R8", go, exp_go);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && go == 0 && sub_start == 0, "R1", {busy, done, go, sub_start}, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0 && go == 0 && sub_start == 0, "R1", {busy, done, go, sub_start}, 0);

    sel_code = 6'b001001;
    start = 1;
    @(negedge clk) start = 0;
    for (int k = 0; k < 4; k++) begin
      check(busy == 0 && sub_start == 0, "R2", {busy, sub_start}, 0);
      @(negedge clk);
    end

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][10:6], VEC[i][5], VEC[i][4], int'(VEC[i][3:1]), VEC[i][0], DW'(12'hA50 + i * 37));
    end

    sel_code = 6'b111110;
    start = 1;
    @(negedge clk) start = 0;
    @(negedge clk);
    check(busy == 0 && sub_start == 0 && go == 0, "R2", {busy, sub_start}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule